// File: doc/BRIEF.md
# Triggered Sample Capture Controller

This block records a single-shot window of ADC samples into an on-chip buffer. Five logic inputs, four target IO lines and one reset line, pass through a per-pin enable mask and one selectable gate. A selectable condition is then detected on the gate output. Once the condition is seen, a programmable post-trigger delay elapses, and then samples are written until the requested record length is reached.

While the block waits for the trigger it keeps writing into the buffer as a ring. This lets the record begin with a chosen number of samples from just before the trigger. A decimation ratio keeps one sample in N. When the record is complete, a done flag rises and stays high until the next arm strobe. Software then reads the record through a synchronous read port. The record starts at the reported start index and runs for the stored count, wrapping at the end of the buffer. The default buffer is modest; full-size builds set `DEPTH` to 24573.

Top module: `trig_capture_ctrl`

## Requirements
- R1: The gate combines only the pins whose `cfg_pin_en` bit is 1. Code `cfg_gate` 0 is OR, 1 is AND, and 2 or 3 is NAND. A masked pin counts as 0 for OR and as 1 for AND/NAND, so toggling it has no effect.
- R2: The trigger fires on a condition of the gate output. Code `cfg_cond` 0 is a rising edge, 1 a falling edge, 2 a high level and 3 a low level. It is evaluated only while armed, starting with the first cycle after the arm cycle.
- R3: With delay D, the first post-trigger sample stored is the one presented D+1 cycles after the trigger cycle.
- R4: With ratio N (where 0 and 1 both mean keep all), one sample in N is stored. The first post-trigger sample is always kept. Presamples are kept every Nth cycle, counting from the first armed cycle.
- R5: The record begins with the most recent K presamples. K is the minimum of `cfg_pre`, the record length and the number of presamples stored since arm. The sample in the trigger cycle itself is not stored.
- R6: The record occupies consecutive addresses modulo DEPTH, starting at `start_idx`. Presample writes wrap around the buffer.
- R7: `stored_cnt` never decreases between arm strobes and equals the record length `cfg_total` (clamped to DEPTH) when done rises. When K already equals the length, done rises in the trigger cycle.
- R8: `done` stays high until the next arm strobe. After an arm strobe, `done` and `stored_cnt` read 0 and detection restarts. No sample is written while done is high.
- R9: `rd_data` returns the word at `rd_addr` one clock later.
- R10: After reset, `done`, `stored_cnt` and `start_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle strobe starting a new capture |
| smp_data | input | SMP_W | ADC sample, one per clock |
| trig_pins | input | NPIN | Trigger inputs (IO lines and reset line) |
| cfg_pin_en | input | NPIN | Per-pin mask for the gate |
| cfg_gate | input | 2 | Gate select |
| cfg_cond | input | 2 | Detection condition select |
| cfg_delay | input | DLY_W | Post-trigger delay in cycles |
| cfg_pre | input | CW | Requested presample count |
| cfg_total | input | CW | Record length |
| cfg_decim | input | DEC_W | Decimation ratio |
| rd_addr | input | AW | Buffer read address |
| rd_data | output | SMP_W | Buffer read data |
| done | output | 1 | Record complete |
| stored_cnt | output | CW | Samples in the record so far |
| start_idx | output | AW | Address of the oldest record sample |

## Verification
The bench builds the block with DEPTH = 61 and otherwise default widths. With this buffer size, an armed wait of about a hundred cycles pushes the presample ring through a full wrap, so the modulo start index and the wrapped readout are reached quickly. Presample requests larger than the available history and larger than the record length are both tried. Delays stay in the hundreds of cycles, which exercises the counter path without spanning the 32-bit range.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam logic [1:0] GATE_OR  = 2'd0;
  localparam logic [1:0] GATE_AND = 2'd1;

  localparam logic [1:0] COND_RISE = 2'd0;
  localparam logic [1:0] COND_FALL = 2'd1;
  localparam logic [1:0] COND_HIGH = 2'd2;
  localparam logic [1:0] COND_LOW  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_WAIT,
    ST_CAPT,
    ST_DONE
  } cap_state_t;
endpackage

// File: rtl/tcap_trigger.sv
module tcap_trigger
  import tcap_pkg::*;
#(
  parameter int NPIN = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pins,
  input  logic [NPIN-1:0] pin_en,
  input  logic [1:0]      gate,
  input  logic [1:0]      cond,
  input  logic            enable,
  output logic            hit
);
  logic any_on, all_on, comb, prev, det;

  always_comb begin
    any_on = |(pins & pin_en);
    all_on = &(pins | ~pin_en);
    case (gate)
      GATE_OR:  comb = any_on;
      GATE_AND: comb = all_on;
      default:  comb = ~all_on;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= comb;
  end

  always_comb begin
    case (cond)
      COND_RISE: det = comb & ~prev;
      COND_FALL: det = ~comb & prev;
      COND_HIGH: det = comb;
      default:   det = ~comb;
    endcase
    hit = enable & det;
  end
endmodule

// File: rtl/tcap_decim.sv
module tcap_decim #(
  parameter int DEC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             advance,
  input  logic [DEC_W-1:0] ratio,
  output logic             tick
);
  logic [DEC_W-1:0] phase, last;

  assign last = (ratio == '0) ? '0 : ratio - 1'b1;
  assign tick = (phase == '0);

  always_ff @(posedge clk) begin
    if (rst || restart)  phase <= '0;
    else if (advance)    phase <= (phase >= last) ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/tcap_ram.sv
module tcap_ram #(
  parameter int W     = 10,
  parameter int DEPTH = 2045,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // R6: the ring pointer must never leave the buffer
  p_waddr_range_r6: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
  import tcap_pkg::*;
#(
  parameter int SMP_W = 10,
  parameter int DEPTH = 2045,
  parameter int NPIN  = 5,
  parameter int DLY_W = 32,
  parameter int DEC_W = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [NPIN-1:0]  trig_pins,
  input  logic [NPIN-1:0]  cfg_pin_en,
  input  logic [1:0]       cfg_gate,
  input  logic [1:0]       cfg_cond,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [CW-1:0]    cfg_pre,
  input  logic [CW-1:0]    cfg_total,
  input  logic [DEC_W-1:0] cfg_decim,
  input  logic [AW-1:0]    rd_addr,
  output logic [SMP_W-1:0] rd_data,
  output logic             done,
  output logic [CW-1:0]    stored_cnt,
  output logic [AW-1:0]    start_idx
);
  cap_state_t       state;
  logic [AW-1:0]    wptr, wptr_nxt, start_c;
  logic [CW-1:0]    seen, tot_eff, pre_eff, kept_c;
  logic [DLY_W-1:0] dcnt;
  logic             hit, dec_tick, cap_active, pre_write, post_write, we;
  logic             restart, advance;
  logic [CW:0]      wp_x, start_x;

  tcap_trigger #(.NPIN(NPIN)) u_trig (
    .clk(clk), .rst(rst), .pins(trig_pins), .pin_en(cfg_pin_en),
    .gate(cfg_gate), .cond(cfg_cond),
    .enable(state == ST_ARMED && !arm), .hit(hit)
  );

  assign cap_active = !arm && ((state == ST_CAPT) || (state == ST_WAIT && dcnt == '0));
  assign restart    = arm || (state == ST_ARMED && hit);
  assign advance    = (state == ST_ARMED) || cap_active;

  tcap_decim #(.DEC_W(DEC_W)) u_dec (
    .clk(clk), .rst(rst), .restart(restart), .advance(advance),
    .ratio(cfg_decim), .tick(dec_tick)
  );

  assign pre_write  = (state == ST_ARMED) && !arm && !hit && dec_tick;
  assign post_write = cap_active && dec_tick;
  assign we         = pre_write || post_write;
  assign wptr_nxt   = (int'(wptr) == DEPTH - 1) ? '0 : wptr + 1'b1;

  always_comb begin
    tot_eff = (cfg_total > CW'(DEPTH)) ? CW'(DEPTH) : cfg_total;
    pre_eff = (cfg_pre > tot_eff) ? tot_eff : cfg_pre;
    kept_c  = (seen < pre_eff) ? seen : pre_eff;
    wp_x    = (CW+1)'(wptr);
    if (wp_x >= (CW+1)'(kept_c)) start_x = wp_x - (CW+1)'(kept_c);
    else                         start_x = wp_x + (CW+1)'(DEPTH) - (CW+1)'(kept_c);
    start_c = AW'(start_x);
  end

  tcap_ram #(.W(SMP_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .rst(rst), .we(we), .waddr(wptr), .wdata(smp_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wptr       <= '0;
      seen       <= '0;
      dcnt       <= '0;
      stored_cnt <= '0;
      start_idx  <= '0;
      done       <= 1'b0;
    end else if (arm) begin
      state      <= ST_ARMED;
      wptr       <= '0;
      seen       <= '0;
      stored_cnt <= '0;
      start_idx  <= '0;
      done       <= 1'b0;
    end else begin
      case (state)
        ST_ARMED: begin
          if (hit) begin
            stored_cnt <= kept_c;
            start_idx  <= start_c;
            dcnt       <= cfg_delay;
            if (kept_c == tot_eff) begin
              state <= ST_DONE;
              done  <= 1'b1;
            end else begin
              state <= ST_WAIT;
            end
          end else if (pre_write) begin
            wptr <= wptr_nxt;
            if (seen != CW'(DEPTH)) seen <= seen + 1'b1;
          end
        end
        ST_WAIT, ST_CAPT: begin
          if (!cap_active) begin
            dcnt <= dcnt - 1'b1;
          end else begin
            state <= ST_CAPT;
            if (post_write) begin
              wptr       <= wptr_nxt;
              stored_cnt <= stored_cnt + 1'b1;
              if (stored_cnt + 1'b1 == tot_eff) begin
                state <= ST_DONE;
                done  <= 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R8: completion persists until re-armed
  p_done_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !arm) |=> done);
  // R8: an arm strobe clears the result
  p_arm_clears_r8: assert property (@(posedge clk) disable iff (rst)
    arm |=> (!done && stored_cnt == '0));
  // R8: a finished record is never overwritten
  p_no_write_done_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !we);
  // R7: the count only grows inside one capture
  p_cnt_grows_r7: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (stored_cnt >= $past(stored_cnt)));
  // R3: nothing is written while the delay is still running
  p_quiet_delay_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && dcnt != '0) |-> !we);
  // R5: the trigger-cycle sample is not stored
  p_skip_trig_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && hit) |-> !we);
endmodule

// File: tb/sim_trig_capture_ctrl.sv
module sim_trig_capture_ctrl;
  localparam int DEPTH = 61;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0;
  logic [9:0]  smp_data = '0;
  logic [4:0]  trig_pins = '0, cfg_pin_en = '0;
  logic [1:0]  cfg_gate = '0, cfg_cond = '0;
  logic [31:0] cfg_delay = '0;
  logic [CW-1:0] cfg_pre = '0, cfg_total = '0;
  logic [15:0] cfg_decim = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [9:0]  rd_data;
  logic        done;
  logic [CW-1:0] stored_cnt;
  logic [AW-1:0] start_idx;

  int checks = 0, errors = 0, ecnt = 0;
  int exp_q[$];

  trig_capture_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .arm(arm), .smp_data(smp_data), .trig_pins(trig_pins),
    .cfg_pin_en(cfg_pin_en), .cfg_gate(cfg_gate), .cfg_cond(cfg_cond),
    .cfg_delay(cfg_delay), .cfg_pre(cfg_pre), .cfg_total(cfg_total),
    .cfg_decim(cfg_decim), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .stored_cnt(stored_cnt), .start_idx(start_idx)
  );

  always #2 clk = ~clk;

  function automatic int fval(int e);
    return (e * 37 + 11) % 1024;
  endfunction

  always @(posedge clk) ecnt <= ecnt + 1;
  always @(negedge clk) smp_data <= 10'(fval(ecnt));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: runs one capture and pushes the expected record into the queue
  task automatic run_cap(string req, logic [1:0] g, logic [1:0] c, logic [4:0] en,
                         logic [4:0] idle, logic [4:0] waitp, logic [4:0] act,
                         int d, int n, int p, int l, int w);
    int a, t, m, nf, seen, kept, st, k;
    @(negedge clk);
    cfg_gate = g; cfg_cond = c; cfg_pin_en = en; trig_pins = idle;
    cfg_delay = d; cfg_decim = 16'(n); cfg_pre = CW'(p); cfg_total = CW'(l);
    @(negedge clk);
    arm = 1'b1; a = ecnt;
    @(negedge clk);
    arm = 1'b0; trig_pins = waitp;
    chk("R8 arm clears done", int'(done), 0);
    chk("R8 arm clears count", int'(stored_cnt), 0);
    for (int i = 1; i < w; i++) @(negedge clk);
    trig_pins = act; t = ecnt;
    nf   = (n == 0) ? 1 : n;
    m    = t - a - 1;
    seen = (m + nf - 1) / nf;
    kept = seen;
    if (p < kept) kept = p;
    if (l < kept) kept = l;
    st = (seen - kept) % DEPTH;
    for (int i = seen - kept; i < seen; i++) exp_q.push_back(fval(a + 1 + i * nf));
    for (int j = 0; j < l - kept; j++) exp_q.push_back(fval(t + 1 + d + j * nf));
    k = 0;
    while (!done && k < 5000) begin @(negedge clk); k++; end
    chk({req, " R7 done reached"}, int'(done), 1);
    chk({req, " R7 stored count"}, int'(stored_cnt), l);
    chk({req, " R6 start index"}, int'(start_idx), st);
    repeat (10) @(negedge clk);
    chk("R8 done holds", int'(done), 1);
    monitor(req, st, l);
  endtask

  // monitor: reads the record back and compares it against the queue
  task automatic monitor(string req, int st, int l);
    int e;
    for (int i = 0; i < l; i++) begin
      rd_addr = AW'((st + i) % DEPTH);
      @(negedge clk);
      e = exp_q.pop_front();
      chk({req, " R9 record data"}, int'(rd_data), e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset done", int'(done), 0);
    chk("R10 reset count", int'(stored_cnt), 0);
    chk("R10 reset start", int'(start_idx), 0);
    // R1 R2: OR, rising; masked pins toggle during the wait
    run_cap("R1 R2 or-rise", 2'd0, 2'd0, 5'b00001, 5'b00000, 5'b11110, 5'b00001, 0, 1, 0, 8, 5);
    // R2 R3: AND, falling, delay 5
    run_cap("R2 R3 and-fall", 2'd1, 2'd1, 5'b00011, 5'b00011, 5'b00011, 5'b00001, 5, 1, 0, 6, 3);
    // R1 R2: NAND, high level
    run_cap("R1 R2 nand-high", 2'd2, 2'd2, 5'b10100, 5'b10100, 5'b10100, 5'b00100, 2, 1, 0, 5, 4);
    // R2: OR, low level
    run_cap("R2 or-low", 2'd0, 2'd3, 5'b01000, 5'b01000, 5'b01000, 5'b00000, 0, 1, 0, 4, 2);
    // R5: presamples with enough history
    run_cap("R5 pre", 2'd0, 2'd0, 5'b00001, 5'b00000, 5'b00000, 5'b00001, 3, 1, 4, 10, 12);
    // R5: presample request exceeds history
    run_cap("R5 clamp", 2'd0, 2'd0, 5'b00001, 5'b00000, 5'b00000, 5'b00001, 0, 1, 6, 10, 2);
    // R6: long armed wait wraps the ring
    run_cap("R6 wrap", 2'd0, 2'd0, 5'b00001, 5'b00000, 5'b00000, 5'b00001, 1, 1, 5, 20, 100);
    // R4: decimation after the trigger only
    run_cap("R4 decim", 2'd0, 2'd0, 5'b00001, 5'b00000, 5'b00000, 5'b00001, 1, 3, 0, 6, 4);
    // R4 R5: decimation with presamples
    run_cap("R4 R5 decim-pre", 2'd0, 2'd0, 5'b00001, 5'b00000, 5'b00000, 5'b00001, 2, 2, 3, 7, 9);
    // R7: presample request covers the whole record
    run_cap("R7 pre-full", 2'd0, 2'd0, 5'b00001, 5'b00000, 5'b00000, 5'b00001, 0, 1, 12, 6, 20);
    // R3: longer delay
    run_cap("R3 long-delay", 2'd0, 2'd0, 5'b00001, 5'b00000, 5'b00000, 5'b00001, 300, 1, 0, 3, 3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule